// File: doc/BRIEF.md
# Windowed Watchdog Timer with Two-Key Servicing

This block is a watchdog that counts clock cycles and raises a one-cycle reset request when software fails to service it in time. A control register picks one of seven time-out lengths (or turns the counter off), turns on a window mode, and decides whether counting pauses while a debug-halt input is high. Software services the watchdog by writing a prime key (0x55) and then a fire key (0xAA) to a separate arm register. The fire key restarts the count from zero.

In window mode the counter also punishes early servicing. Any arm write during the first three quarters of the period raises a reset request. Once the window is open, the prime key may be repeated freely, and the fire key closes the window again until three quarters of the new period have passed. In user mode the rate and window fields accept one write after reset and then lock. In special mode they stay writable at any time. The debug-pause bit accepts one write after reset in either mode.

Period lengths are 2^(B+k) cycles, where B is the parameter `EXP_BASE` (default 14) and k is 0, 2, 4, 6, 8, 9 or 10 for rate codes 1 to 7. The default therefore gives periods of 2^14 up to 2^24 cycles.

Top module: `wdt_windowed`

## Requirements
- R1: Control register layout: window enable in bit 7, debug pause in bit 6, rate code in bits 2:0. Rate code 0 stops the counter, and no reset request is ever produced while it is 0.
- R2: Rate codes 1..7 select periods of 2^(B), 2^(B+2), 2^(B+4), 2^(B+6), 2^(B+8), 2^(B+9) and 2^(B+10) cycles. The request pulse appears exactly one period of clock edges after the control write that started the count.
- R3: Every accepted control write clears the counter, so a nonzero rate write begins a fresh full period.
- R4: A 0x55 arm write followed by a 0xAA arm write restarts the period from zero. A fire key that lands in the same cycle as the last count of the period wins, and no request is raised.
- R5: While the counter runs, an arm write of any value other than 0x55 or 0xAA, or a 0xAA that does not follow a 0x55, raises the request in the next cycle. While the rate code is 0, arm writes are ignored and raise nothing.
- R6: In window mode, an arm write seen while the count is below 3/4 of the period raises the request. Writes at or above that point are accepted.
- R7: In window mode, 0x55 may be repeated inside the open window. After the 0xAA restart, the next arm write raises the request until 3/4 of the new period has elapsed.
- R8: In user mode, the window and rate fields take only the first control write after reset. In special mode every control write updates them.
- R9: The debug-pause bit takes only the first control write after reset, in either mode. When it is set and the debug input is high, the count holds. When it is clear, the debug input has no effect.
- R10: After reset the control register reads 0x00. Bits 5:3 always read zero, and reading the arm register (address 1) returns 0x00.
- R11: The request is a single-cycle pulse. Along with it the counter clears and any pending 0x55 is forgotten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock that the counter runs on |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 1 | 0 selects the control register, 1 selects the arm register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected address (combinational) |
| dbg_active | input | 1 | High while the debug halt is active |
| special_mode | input | 1 | High when the device is in special mode |
| wdt_reset_req | output | 1 | One-cycle reset request |

## Verification
A write takes effect at the clock edge that samples its strobe. Any request it provokes is visible from that same edge, so the bench drives each write on a falling edge and checks the request at the next falling edge. A time-out is due a full period of edges after its restarting edge. The bench idles one cycle less than the period and checks for silence, idles one more cycle and expects the pulse, then idles one more and expects the pulse to have dropped. Paused cycles extend that count one for one. Readback is combinational and is sampled a time step after the address changes. The bench shortens the periods by lowering `EXP_BASE` to 4, which keeps all seven rates within reach of the run.

// File: rtl/wdt_pkg.sv
// Package: shared constants, configuration type and rate helpers for the
// windowed watchdog. Assumes an 8-bit register bus.
package wdt_pkg;

    localparam int DATA_W    = 8;
    localparam int RATE_W    = 3;
    localparam int NUM_CODES = 1 << RATE_W;
    localparam int WIN_BIT   = 7;
    localparam int DBG_BIT   = 6;
    localparam int MAX_OFFSET = 10;

    localparam logic [DATA_W-1:0] KEY_PRIME = 8'h55;
    localparam logic [DATA_W-1:0] KEY_FIRE  = 8'hAA;

    typedef struct packed {
        logic              win;
        logic              dbg_stop;
        logic [RATE_W-1:0] rate;
    } wdt_cfg_t;

    // Exponent offset over the base exponent for each nonzero rate code.
    function automatic int unsigned rate_offset(input int unsigned code);
        case (code)
            1:       return 0;
            2:       return 2;
            3:       return 4;
            4:       return 6;
            5:       return 8;
            6:       return 9;
            7:       return 10;
            default: return 0;
        endcase
    endfunction

    // Control register image as seen on the read bus; unused bits are zero.
    function automatic logic [DATA_W-1:0] cfg_pack(input wdt_cfg_t c);
        logic [DATA_W-1:0] v;
        v = '0;
        v[WIN_BIT] = c.win;
        v[DBG_BIT] = c.dbg_stop;
        v[RATE_W-1:0] = c.rate;
        return v;
    endfunction

endpackage

// File: rtl/wdt_ctrl_regs.sv
// Control register with write-once locks.
// The window and rate fields lock after the first user-mode write; special-mode
// writes neither check nor set that lock. The debug-pause bit locks after its
// first write in any mode. Any accepted rate/window write pulses restart.
module wdt_ctrl_regs
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              special_mode,
    input  logic [DATA_W-1:0] wdata,
    output wdt_cfg_t          cfg,
    output logic              cfg_locked,
    output logic              dbg_locked,
    output logic              restart
);

    logic main_ok;

    // Decide whether the window/rate part of a write is accepted.
    always_comb begin
        main_ok = ctrl_wr && (special_mode || !cfg_locked);
        restart = main_ok;
    end

    // Hold the fields and their lock flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg        <= '0;
            cfg_locked <= 1'b0;
            dbg_locked <= 1'b0;
        end else begin
            if (main_ok) begin
                cfg.win  <= wdata[WIN_BIT];
                cfg.rate <= wdata[RATE_W-1:0];
                if (!special_mode) begin
                    cfg_locked <= 1'b1;
                end
            end
            if (ctrl_wr && !dbg_locked) begin
                cfg.dbg_stop <= wdata[DBG_BIT];
                dbg_locked   <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/wdt_counter.sv
// Period counter. It builds one limit and one window threshold per rate code
// with generate, then selects by the current code. Assumes EXP_BASE >= 2, so
// a quarter period is a whole number of cycles.
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int EXP_BASE = 14,
    parameter int CNT_W    = EXP_BASE + MAX_OFFSET
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate,
    input  logic              count_en,
    input  logic              restart,
    output logic              at_limit,
    output logic              win_open,
    output logic [CNT_W-1:0]  cnt_q
);

    logic [CNT_W-1:0] last_tab [NUM_CODES];
    logic [CNT_W-1:0] thr_tab  [NUM_CODES];
    logic [CNT_W-1:0] last_sel;
    logic [CNT_W-1:0] thr_sel;

    for (genvar g = 0; g < NUM_CODES; g++) begin : g_code
        if (g == 0) begin : g_off
            assign last_tab[g] = '1;
            assign thr_tab[g]  = '1;
        end else begin : g_on
            localparam int unsigned EXP = EXP_BASE + rate_offset(g);
            assign last_tab[g] = CNT_W'((64'd1 << EXP) - 64'd1);
            assign thr_tab[g]  = CNT_W'(64'd3 << (EXP - 2));
        end
    end

    // Select the limit and threshold for the current code and flag them.
    always_comb begin
        last_sel = last_tab[rate];
        thr_sel  = thr_tab[rate];
        at_limit = count_en && (cnt_q == last_sel);
        win_open = (cnt_q >= thr_sel);
    end

    // Advance, hold or clear the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (count_en) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/wdt_arm_seq.sv
// Arm-register key decoder. It tracks whether a prime key is pending and
// classifies each arm write as prime, service or violation. Arm writes are
// ignored while the counter is off.
module wdt_arm_seq
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              enabled,
    input  logic              window_en,
    input  logic              win_open,
    input  logic              clr,
    output logic              service,
    output logic              violation
);

    logic primed_q;
    logic prime_hit;

    // Classify the current arm write.
    always_comb begin
        service   = 1'b0;
        violation = 1'b0;
        prime_hit = 1'b0;
        if (arm_wr && enabled) begin
            if (window_en && !win_open) begin
                violation = 1'b1;
            end else if (wdata == KEY_PRIME) begin
                prime_hit = 1'b1;
            end else if (wdata == KEY_FIRE && primed_q) begin
                service = 1'b1;
            end else begin
                violation = 1'b1;
            end
        end
    end

    // Remember a pending prime key until it is used or cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            primed_q <= 1'b0;
        end else if (clr || service || violation) begin
            primed_q <= 1'b0;
        end else if (prime_hit) begin
            primed_q <= 1'b1;
        end
    end

endmodule

// File: rtl/wdt_windowed.sv
// Windowed watchdog top. It joins the control register, the key decoder and
// the period counter, and registers the one-cycle reset request. Assumes
// single-cycle write strobes and a synchronous active-low reset.
module wdt_windowed
    import wdt_pkg::*;
#(
    parameter int EXP_BASE = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              dbg_active,
    input  logic              special_mode,
    output logic              wdt_reset_req
);

    localparam int CNT_W = EXP_BASE + MAX_OFFSET;

    wdt_cfg_t         cfg;
    logic             cfg_locked;
    logic             dbg_locked;
    logic             ctrl_restart;
    logic             ctrl_wr;
    logic             arm_wr;
    logic             enabled;
    logic             count_en;
    logic             at_limit;
    logic             win_open;
    logic             service;
    logic             violation;
    logic             req_set;
    logic             cnt_restart;
    logic [CNT_W-1:0] cnt_q;

    // Decode strobes, the run state and the request condition.
    always_comb begin
        ctrl_wr     = bus_wr && !bus_addr;
        arm_wr      = bus_wr && bus_addr;
        enabled     = (cfg.rate != '0);
        count_en    = enabled && !(cfg.dbg_stop && dbg_active);
        req_set     = violation || (at_limit && !service);
        cnt_restart = ctrl_restart || service || req_set;
        bus_rdata   = bus_addr ? '0 : cfg_pack(cfg);
    end

    wdt_ctrl_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_wr      (ctrl_wr),
        .special_mode (special_mode),
        .wdata        (bus_wdata),
        .cfg          (cfg),
        .cfg_locked   (cfg_locked),
        .dbg_locked   (dbg_locked),
        .restart      (ctrl_restart)
    );

    wdt_arm_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_wr    (arm_wr),
        .wdata     (bus_wdata),
        .enabled   (enabled),
        .window_en (cfg.win),
        .win_open  (win_open),
        .clr       (req_set || ctrl_restart),
        .service   (service),
        .violation (violation)
    );

    wdt_counter #(
        .EXP_BASE (EXP_BASE),
        .CNT_W    (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate     (cfg.rate),
        .count_en (count_en),
        .restart  (cnt_restart),
        .at_limit (at_limit),
        .win_open (win_open),
        .cnt_q    (cnt_q)
    );

    // Register the one-cycle reset request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdt_reset_req <= 1'b0;
        end else begin
            wdt_reset_req <= req_set;
        end
    end

endmodule

// File: rtl/wdt_windowed_chk.sv
// Checker for the windowed watchdog, bound to the top module. It observes
// ports and internal configuration state only.
module wdt_windowed_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic             special_mode,
    input logic             dbg_active,
    input logic             req,
    input logic [2:0]       rate,
    input logic             win,
    input logic             dbg_stop,
    input logic             cfg_locked,
    input logic             dbg_locked,
    input logic [CNT_W-1:0] cnt
);

    // R1: with the counter off, no request follows.
    assert_off_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rate == 3'd0) |=> !req);

    // R11: without a new write, the request lasts one cycle.
    assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !bus_wr) |=> !req);

    // R8: locked fields do not change in user mode.
    assert_user_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_locked && !special_mode) |=> ($stable(rate) && $stable(win)));

    // R9: the debug-pause bit does not change once locked.
    assert_dbg_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_locked |=> $stable(dbg_stop));

    // R9: the count holds while paused and no write arrives.
    assert_freeze_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_stop && dbg_active && !bus_wr) |=> $stable(cnt));

endmodule

bind wdt_windowed wdt_windowed_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .special_mode (special_mode),
    .dbg_active   (dbg_active),
    .req          (wdt_reset_req),
    .rate         (cfg.rate),
    .win          (cfg.win),
    .dbg_stop     (cfg.dbg_stop),
    .cfg_locked   (cfg_locked),
    .dbg_locked   (dbg_locked),
    .cnt          (cnt_q)
);

// File: tb/wdt_windowed_test.sv
`timescale 1ns/1ps
module wdt_windowed_test;

    localparam int EB = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic       dbg_active = 1'b0;
    logic       special_mode = 1'b0;
    logic [7:0] bus_rdata;
    logic       req;

    int errors = 0;
    int checks = 0;

    wdt_windowed #(.EXP_BASE(EB)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_wr        (bus_wr),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .dbg_active    (dbg_active),
        .special_mode  (special_mode),
        .wdt_reset_req (req)
    );

    always #5 clk = ~clk;

    function automatic int period_of(input int r);
        int off;
        case (r)
            1: off = 0;   2: off = 2;   3: off = 4;   4: off = 6;
            5: off = 8;   6: off = 9;   default: off = 10;
        endcase
        return 1 << (EB + off);
    endfunction

    function automatic int thresh_of(input int r);
        return period_of(r) - period_of(r) / 4;
    endfunction

    function automatic logic [7:0] ctrl_img(input bit w, input bit d, input int r);
        return {w, d, 3'b000, 3'(r)};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        bus_wr = 1'b0;
        dbg_active = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
    endtask

    task automatic wr(input bit a, input logic [7:0] d);
        bus_addr = a;
        bus_wdata = d;
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input bit a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    // Expect a time-out pulse exactly p edges after the last restart edge.
    task automatic expect_to(input string tag, input int p);
        idle(p - 1);
        chk({tag, " quiet before period"}, int'(req), 0);
        idle(1);
        chk({tag, " pulse at period"}, int'(req), 1);
        idle(1);
        chk({tag, " pulse width R11"}, int'(req), 0);
    endtask

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
    end

    initial begin
        logic [7:0] v;
        bit         seen;
        void'($urandom(32'd4711));
        do_reset();

        // R10: reset state and readback.
        rd(1'b0, v); chk("R10 ctrl after reset", v, 8'h00);
        rd(1'b1, v); chk("R10 arm reads zero", v, 8'h00);
        chk("R10 no request after reset", int'(req), 0);
        seen = 0;
        for (int i = 0; i < 200; i++) begin @(negedge clk); if (req) seen = 1; end
        chk("R1 idle after reset stays silent", int'(seen), 0);
        special_mode = 1'b1;
        wr(1'b0, 8'hFF);
        rd(1'b0, v); chk("R10 unused bits zero", v, 8'hC7);
        rd(1'b1, v); chk("R10 arm readback", v, 8'h00);

        // R8/R9: user-mode write-once and special-mode rewrite.
        do_reset();
        special_mode = 1'b0;
        wr(1'b0, 8'h02);
        rd(1'b0, v); chk("R8 first user write", v, 8'h02);
        wr(1'b0, 8'hC5);
        rd(1'b0, v); chk("R8 second user write ignored", v, 8'h02);
        special_mode = 1'b1;
        wr(1'b0, 8'hC1);
        rd(1'b0, v); chk("R8 special rewrite, R9 dbg locked", v, 8'h81);

        // R2: every rate code times out after its own period.
        for (int r = 1; r <= 7; r++) begin
            do_reset();
            special_mode = 1'b1;
            wr(1'b0, ctrl_img(0, 0, r));
            expect_to($sformatf("R2 rate %0d", r), period_of(r));
        end

        // R3: rewriting the rate restarts the period.
        do_reset();
        special_mode = 1'b1;
        wr(1'b0, 8'h01);
        idle(10);
        wr(1'b0, 8'h01);
        expect_to("R3 restart on rate write", period_of(1));

        // R1: rate zero stops the counter.
        wr(1'b0, 8'h00);
        seen = 0;
        for (int i = 0; i < 100; i++) begin @(negedge clk); if (req) seen = 1; end
        chk("R1 disabled silent", int'(seen), 0);

        // R4: service in the final cycle of the period wins.
        do_reset();
        wr(1'b0, 8'h01);
        idle(14);
        wr(1'b1, 8'h55); chk("R4 prime accepted", int'(req), 0);
        wr(1'b1, 8'hAA); chk("R4 fire at last count", int'(req), 0);
        expect_to("R4 new period", period_of(1));

        // R5/R11: bad keys raise a request, and the violation forgets the prime.
        do_reset();
        wr(1'b0, 8'h02);
        wr(1'b1, 8'h55);
        wr(1'b1, 8'h12); chk("R5 bad key", int'(req), 1);
        idle(1);         chk("R11 pulse drops", int'(req), 0);
        wr(1'b1, 8'hAA); chk("R11 prime forgotten, R5 lone fire", int'(req), 1);
        do_reset();
        wr(1'b1, 8'h12); chk("R5 ignored while off (bad)", int'(req), 0);
        wr(1'b1, 8'hAA); chk("R5 ignored while off (fire)", int'(req), 0);

        // R6/R7: window boundaries.
        do_reset();
        special_mode = 1'b1;
        wr(1'b0, 8'h82);
        idle(thresh_of(2) - 1);
        wr(1'b1, 8'h55); chk("R6 one cycle before window", int'(req), 1);
        wr(1'b0, 8'h82);
        idle(thresh_of(2));
        wr(1'b1, 8'h55); chk("R6 at window start", int'(req), 0);
        wr(1'b1, 8'h55); chk("R7 repeated prime", int'(req), 0);
        wr(1'b1, 8'hAA); chk("R7 fire in window", int'(req), 0);
        wr(1'b1, 8'h55); chk("R7 window closed after fire", int'(req), 1);

        // R9: pause holds the count; without the bit, debug has no effect.
        do_reset();
        special_mode = 1'b0;
        wr(1'b0, 8'h41);
        idle(5);
        dbg_active = 1'b1;
        seen = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (req) seen = 1; end
        dbg_active = 1'b0;
        chk("R9 silent while paused", int'(seen), 0);
        idle(10); chk("R9 quiet before extended period", int'(req), 0);
        idle(1);  chk("R9 pulse after extended period", int'(req), 1);
        do_reset();
        wr(1'b0, 8'h01);
        dbg_active = 1'b1;
        expect_to("R9 no pause when bit clear", period_of(1));
        dbg_active = 1'b0;

        // R4/R6: random service times in both modes.
        do_reset();
        special_mode = 1'b1;
        for (int it = 0; it < 40; it++) begin
            int  r;
            int  d;
            bit  w;
            bit  bad;
            r = 1 + int'($urandom % 3);
            w = bit'($urandom % 2);
            d = int'($urandom % (period_of(r) - 2));
            wr(1'b0, ctrl_img(w, 0, r));
            idle(d);
            bad = w && (d < thresh_of(r));
            wr(1'b1, 8'h55);
            chk($sformatf("R6 random prime w=%0d d=%0d", w, d), int'(req), int'(bad));
            if (!bad) begin
                wr(1'b1, 8'hAA);
                chk("R4 random fire", int'(req), 0);
            end
            expect_to("R4 random follow-up period", period_of(r));
        end

        summary();
    end

endmodule